// File: doc/BRIEF.md
# Strap-Selected Host Compatibility Logic

This block adapts a disk controller's host-side signals to one of three system personalities. Two strap pins are sampled while the hardware reset is held, and the personality they pick is kept until the next hardware reset. The personality decides three things. It sets the polarity of the density-select output. It sets the active level of the terminal-count input. It decides whether a DMA-gate bit may float the request and interrupt outputs.

The block also holds the host-programmable transfer settings: a two-bit data-rate code and a three-bit write-precompensation code. Both are loaded from register writes and are driven out to the rest of the controller. A hardware reset puts them back to their defaults. A software reset leaves them as they are.

Top module: `host_compat_logic`

## Requirements
- R1: While `hw_rst` is high, the personality is taken from the straps on every clock edge: `strap_ident`=1 selects the AT personality, `strap_ident`=0 with `strap_enc`=1 selects the PS personality, and `strap_ident`=0 with `strap_enc`=0 selects the M30 personality. Strap changes while `hw_rst` is low have no effect.
- R2: A clock edge with `hw_rst` high sets the rate code to 10b, the precompensation code to 000b and the DMA-gate bit to 0.
- R3: Rate codes 00b and 11b are high rates; 10b and 01b are not. With `invert_in`=0, `densel` is 1 for a high rate in the AT personality, and 0 for a high rate in the PS and M30 personalities. With `invert_in`=1 the result is inverted.
- R4: In the PS personality, `drq_oe` and `int_oe` are 1 whatever the DMA-gate bit holds.
- R5: In the AT and M30 personalities, `drq_oe` and `int_oe` both equal the DMA-gate bit. A write with `wr_sel`=0 loads that bit from `wr_data[3]`, and the new value is visible after the clock edge of the write.
- R6: The terminal count is active low (`tc_in`=0) in the PS personality and active high in the AT and M30 personalities.
- R7: `tc_q` is 0 whenever `dack_n` is 1. Otherwise `tc_q` is 1 exactly when `tc_in` is at its active level.
- R8: A write with `wr_sel`=1 and `wr_data[7]`=0 loads the rate code from `wr_data[1:0]` and the precompensation code from `wr_data[4:2]`. A write with `wr_sel`=2 loads only the rate code, from `wr_data[1:0]`. A write with `wr_sel`=3 changes nothing.
- R9: A software reset leaves the rate and precompensation codes unchanged. It is either a write with `wr_sel`=1 and `wr_data[7]`=1, or a write with `wr_sel`=0 and `wr_data[2]`=0. The `wr_sel`=1 form also clears the DMA-gate bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, active high, synchronous |
| strap_ident | input | 1 | Personality strap, system type |
| strap_enc | input | 1 | Personality strap, encoding |
| invert_in | input | 1 | Inverts the density-select polarity |
| tc_in | input | 1 | Raw terminal count |
| dack_n | input | 1 | DMA acknowledge, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 output/gate, 1 rate select, 2 rate only, 3 none |
| wr_data | input | 8 | Write data |
| densel | output | 1 | Density select |
| tc_q | output | 1 | Qualified terminal count, active high |
| drq_oe | output | 1 | Drive enable for the DMA request output |
| int_oe | output | 1 | Drive enable for the interrupt output |
| rate_o | output | 2 | Current data-rate code |
| pcmp_o | output | 3 | Current write-precompensation code |

## Verification
The bench builds the block with its default reset codes: rate 10b and precompensation 000b. With these values the hardware-reset state is a low rate, so `densel` sits at its inactive level straight after reset in every personality. All three personalities are entered by repeated hardware resets, with the straps moved afterwards to show they are ignored. In each personality, random writes, TC and DACK levels and invert settings sweep every rate code, both gate values and both software-reset forms.

// File: rtl/host_compat_logic.sv
module host_compat_logic #(
  parameter logic [1:0] RATE_RST = 2'b10,
  parameter logic [2:0] PCMP_RST = 3'b000
) (
  input  logic       clk,
  input  logic       hw_rst,
  input  logic       strap_ident,
  input  logic       strap_enc,
  input  logic       invert_in,
  input  logic       tc_in,
  input  logic       dack_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       densel,
  output logic       tc_q,
  output logic       drq_oe,
  output logic       int_oe,
  output logic [1:0] rate_o,
  output logic [2:0] pcmp_o
);

  localparam int GATE_BIT = 3;
  localparam int RUN_BIT  = 2;
  localparam int SRST_BIT = 7;
  localparam logic [1:0] SEL_OUT = 2'd0, SEL_DSR = 2'd1, SEL_CCR = 2'd2;

  typedef enum logic [1:0] {PM_PS = 2'd0, PM_AT = 2'd1, PM_M30 = 2'd2} pmode_t;

  pmode_t     mode_q;
  logic       gate_q;
  logic [1:0] rate_q;
  logic [2:0] pcmp_q;

  wire wr_out  = wr_en && wr_sel == SEL_OUT;
  wire wr_dsr  = wr_en && wr_sel == SEL_DSR;
  wire wr_ccr  = wr_en && wr_sel == SEL_CCR;
  wire dsr_rst = wr_dsr && wr_data[SRST_BIT];

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      mode_q <= strap_ident ? PM_AT : (strap_enc ? PM_PS : PM_M30);
      gate_q <= 1'b0;
      rate_q <= RATE_RST;
      pcmp_q <= PCMP_RST;
    end else begin
      if (wr_out)       gate_q <= wr_data[GATE_BIT];
      else if (dsr_rst) gate_q <= 1'b0;
      if (wr_dsr && !dsr_rst) begin
        rate_q <= wr_data[1:0];
        pcmp_q <= wr_data[4:2];
      end else if (wr_ccr) begin
        rate_q <= wr_data[1:0];
      end
    end
  end

  wire high_rate = (rate_q == 2'b00) || (rate_q == 2'b11);
  wire pol_high  = (mode_q == PM_AT) ^ invert_in;
  wire tc_act    = (mode_q == PM_PS) ? !tc_in : tc_in;
  wire drive_all = (mode_q == PM_PS) || gate_q;

  assign densel = pol_high ? high_rate : !high_rate;
  assign tc_q   = !dack_n && tc_act;
  assign drq_oe = drive_all;
  assign int_oe = drive_all;
  assign rate_o = rate_q;
  assign pcmp_o = pcmp_q;

  a_r1_mode_hold: assert property (@(posedge clk) disable iff (hw_rst)
    !hw_rst |=> $stable(mode_q));

  a_r2_hw_defaults: assert property (@(posedge clk)
    hw_rst |=> (rate_o == RATE_RST && pcmp_o == PCMP_RST));

  a_r5_gate_load: assert property (@(posedge clk) disable iff (hw_rst)
    (wr_out && wr_data[GATE_BIT]) |=> (drq_oe && int_oe));

  a_r7_tc_qual: assert property (@(posedge clk) disable iff (hw_rst)
    dack_n |-> !tc_q);

  a_r9_soft_keep: assert property (@(posedge clk) disable iff (hw_rst)
    (dsr_rst || (wr_out && !wr_data[RUN_BIT])) |=> ($stable(rate_o) && $stable(pcmp_o)));

  a_r4_ps_drive: assert property (@(posedge clk) disable iff (hw_rst)
    (mode_q == PM_PS) |-> (drq_oe && int_oe));

endmodule

// File: tb/sim_host_compat_logic.sv
module sim_host_compat_logic;
  logic clk = 0;
  logic hw_rst = 1, strap_ident = 0, strap_enc = 1, invert_in = 0, tc_in = 0, dack_n = 1;
  logic wr_en = 0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic densel, tc_q, drq_oe, int_oe;
  logic [1:0] rate_o;
  logic [2:0] pcmp_o;

  int checks = 0, errors = 0;
  int m_mode;
  logic m_gate;
  logic [1:0] m_rate;
  logic [2:0] m_pcmp;

  always #10 clk = ~clk;

  host_compat_logic u0 (.clk, .hw_rst, .strap_ident, .strap_enc, .invert_in, .tc_in, .dack_n,
    .wr_en, .wr_sel, .wr_data, .densel, .tc_q, .drq_oe, .int_oe, .rate_o, .pcmp_o);

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic exp_densel(int md, logic [1:0] r, logic inv);
    logic hi = (r == 2'b00) || (r == 2'b11);
    logic pol = (md == 1) ^ inv;
    return pol ? hi : !hi;
  endfunction

  function automatic logic exp_tc(int md, logic t, logic dn);
    if (dn) return 1'b0;
    return (md == 0) ? !t : t;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 densel", {7'd0, densel}, {7'd0, exp_densel(m_mode, m_rate, invert_in)});
    chk((m_mode == 0) ? "R6 tc level" : "R7 tc qual", {7'd0, tc_q}, {7'd0, exp_tc(m_mode, tc_in, dack_n)});
    chk((m_mode == 0) ? "R4 drq_oe" : "R5 drq_oe", {7'd0, drq_oe}, {7'd0, (m_mode == 0) | m_gate});
    chk((m_mode == 0) ? "R4 int_oe" : "R5 int_oe", {7'd0, int_oe}, {7'd0, (m_mode == 0) | m_gate});
    chk("R8 rate", {6'd0, rate_o}, {6'd0, m_rate});
    chk("R8 pcmp", {5'd0, pcmp_o}, {5'd0, m_pcmp});
  endtask

  task automatic clock_write(logic en, logic [1:0] sel, logic [7:0] d);
    wr_en = en; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    if (en && !hw_rst) begin
      if (sel == 0) m_gate = d[3];
      else if (sel == 1 && d[7]) m_gate = 1'b0;
      if (sel == 1 && !d[7]) begin m_rate = d[1:0]; m_pcmp = d[4:2]; end
      else if (sel == 2) m_rate = d[1:0];
    end
    wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic do_hw_reset(logic id, logic enc, int md);
    strap_ident = id; strap_enc = enc; hw_rst = 1;
    @(posedge clk); @(posedge clk); #1;
    hw_rst = 0;
    m_mode = md; m_gate = 0; m_rate = 2'b10; m_pcmp = 3'b000;
    chk("R2 rate default", {6'd0, rate_o}, 8'h02);
    chk("R2 pcmp default", {5'd0, pcmp_o}, 8'h00);
    chk("R2 gate default", {7'd0, drq_oe}, {7'd0, md == 0});
    strap_ident = ~id; strap_enc = ~enc;
    clock_write(0, 2'd3, 8'h00);
    check_all();
    chk("R1 straps ignored after reset", {7'd0, drq_oe}, {7'd0, md == 0});
  endtask

  task automatic run_mode(logic id, logic enc, int md);
    logic [1:0] r0;
    logic [2:0] p0;
    do_hw_reset(id, enc, md);
    clock_write(1, 2'd1, 8'b0_000_1_0_11);
    chk("R8 dsr load rate", {6'd0, rate_o}, 8'h03);
    chk("R8 dsr load pcmp", {5'd0, pcmp_o}, 8'h02);
    r0 = rate_o; p0 = pcmp_o;
    clock_write(1, 2'd1, 8'b1000_0000);
    chk("R9 dsr soft reset keeps rate", {6'd0, rate_o}, {6'd0, r0});
    chk("R9 dsr soft reset keeps pcmp", {5'd0, pcmp_o}, {5'd0, p0});
    clock_write(1, 2'd0, 8'b0000_1000);
    chk("R5 gate set", {7'd0, drq_oe}, 8'h01);
    clock_write(1, 2'd1, 8'b1000_0000);
    chk("R9 dsr soft reset clears gate", {7'd0, int_oe}, {7'd0, md == 0});
    clock_write(1, 2'd0, 8'b0000_0000);
    chk("R9 dor soft reset keeps rate", {6'd0, rate_o}, {6'd0, r0});
    clock_write(1, 2'd2, 8'b1111_1101);
    chk("R8 ccr rate only", {6'd0, rate_o}, 8'h01);
    chk("R8 ccr keeps pcmp", {5'd0, pcmp_o}, {5'd0, p0});
    clock_write(1, 2'd3, 8'hFF);
    chk("R8 sel3 ignored rate", {6'd0, rate_o}, 8'h01);
    chk("R8 sel3 ignored gate", {7'd0, drq_oe}, {7'd0, md == 0});
    for (int i = 0; i < 400; i++) begin
      invert_in = $urandom_range(0, 1);
      tc_in = $urandom_range(0, 1);
      dack_n = $urandom_range(0, 1);
      strap_ident = $urandom_range(0, 1);
      strap_enc = $urandom_range(0, 1);
      clock_write($urandom_range(0, 1), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
      check_all();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    run_mode(1'b0, 1'b1, 0);
    run_mode(1'b1, 1'b0, 1);
    run_mode(1'b0, 1'b0, 2);
    run_mode(1'b1, 1'b1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule